// File: doc/BRIEF.md
# Interval Timer with Selectable Count Clock

This block is an 8-bit interval timer. It raises a periodic interrupt request at a fixed spacing. Software loads a compare value N, picks a count-clock rate from a prescaler with a 3-bit code, and then sets a run bit. From that point the counter steps up on every prescaler tick. On the tick where the counter equals N, the counter returns to 00H and a one-cycle interrupt pulse is raised. The spacing between pulses is therefore (N + 1) count-clock periods.

Access is through a small synchronous register port: a write strobe with address and data, and a combinational read mux that also exposes the live counter. Clearing the run bit stops counting, returns the counter to 00H and restarts the prescaler, so each new start measures a full interval. A hold bit in the control register parks the counter while run is set. The compare value is locked while run is set.

Top module: `ivt_timer`

## Requirements
- R1: After reset, the compare, clock-select and control registers, the counter and `irq` are all 0.
- R2: Register addresses: 0 is the 8-bit compare value; 1 is the clock-select code in bits [2:0], with the upper bits reading 0; 2 is control, with bit 0 = run and bit 1 = hold; 3 is the counter (read-only). `rd_data` shows the addressed register in the same cycle.
- R3: A clock-select code c gives one count tick every 2^k system clocks, with k = 0,1,2,3,4,6,8,10 for c = 0..7.
- R4: With run=1 and hold=0, the counter clears to 00H on the tick where it equals the compare value N, and `irq` is raised. The first pulse comes (N+1)·2^k clocks after the edge that writes run=1, and later pulses come every (N+1)·2^k clocks.
- R5: `irq` is high for exactly one system clock per match. It appears on the same edge that clears the counter.
- R6: While running, the counter reads 00H after the start and advances by one on each tick.
- R7: A write to the compare register while run=1 is ignored.
- R8: Writing run=0 stops all ticks and interrupts. The counter reads 00H from the second edge after the write. The prescaler restarts, so a later run=1 gives a full first interval.
- R9: With run=1 and hold=1, the counter stays at 00H and no interrupt is raised.
- R10: Writes to address 3 have no effect on any register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address |
| wr_data | input | 8 | Write data |
| rd_addr | input | 2 | Read address |
| rd_data | output | 8 | Read data, combinational |
| irq | output | 1 | One-cycle interrupt request on a match |

## Verification
A write takes effect on the edge that samples the strobe, and that edge is counted as edge zero. A run=1 write therefore produces its first `irq` on edge (N+1)·2^k, and the bench samples at the falling edge after each rising edge to find that exact index. After a run=0 write, the counter holds its value for one cycle and reads 00H from the second edge. The bench reads it there, and not at the first edge. Read-back is combinational, so register values are sampled 1 ns after the read address is set, in the same cycle.

// File: rtl/ivt_pkg.sv
package ivt_pkg;

   localparam int ADDR_W = 2;

   localparam logic [ADDR_W-1:0] A_CMP = 2'd0;
   localparam logic [ADDR_W-1:0] A_SEL = 2'd1;
   localparam logic [ADDR_W-1:0] A_CTL = 2'd2;
   localparam logic [ADDR_W-1:0] A_CNT = 2'd3;

   localparam int CTL_RUN  = 0;
   localparam int CTL_HOLD = 1;

   // divide exponent for a clock-select code: 0..4 direct, then 6, 8, 10
   function automatic int sel_shift(input int code);
      return (code <= 4) ? code : (2 * code - 4);
   endfunction

endpackage

// File: rtl/ivt_regs.sv
module ivt_regs
   import ivt_pkg::*;
#(
   parameter int CNT_W = 8,
   parameter int SEL_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [CNT_W-1:0]  wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   input  logic [CNT_W-1:0]  cnt,
   output logic [CNT_W-1:0]  rd_data,
   output logic [CNT_W-1:0]  cmp_q,
   output logic [SEL_W-1:0]  sel_q,
   output logic              run_q,
   output logic              hold_q
);

   localparam int SEL_PAD = CNT_W - SEL_W;
   localparam int CTL_PAD = CNT_W - 2;

   logic wr_cmp, wr_sel, wr_ctl;

   assign wr_cmp = wr_en && (wr_addr == A_CMP) && !run_q;
   assign wr_sel = wr_en && (wr_addr == A_SEL);
   assign wr_ctl = wr_en && (wr_addr == A_CTL);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cmp_q  <= '0;
         sel_q  <= '0;
         run_q  <= 1'b0;
         hold_q <= 1'b0;
      end else begin
         if (wr_cmp) cmp_q <= wr_data;
         if (wr_sel) sel_q <= wr_data[SEL_W-1:0];
         if (wr_ctl) begin
            run_q  <= wr_data[CTL_RUN];
            hold_q <= wr_data[CTL_HOLD];
         end
      end
   end

   always_comb begin
      unique case (rd_addr)
         A_CMP:   rd_data = cmp_q;
         A_SEL:   rd_data = {{SEL_PAD{1'b0}}, sel_q};
         A_CTL:   rd_data = {{CTL_PAD{1'b0}}, hold_q, run_q};
         default: rd_data = cnt;
      endcase
   end

   AST_CMP_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
      $past(run_q) |-> $stable(cmp_q)); // R7

endmodule

// File: rtl/ivt_prescaler.sv
module ivt_prescaler
   import ivt_pkg::*;
#(
   parameter int SEL_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             active,
   input  logic [SEL_W-1:0] sel,
   output logic             tick
);

   localparam int NCODE = 2 ** SEL_W;
   localparam int MAX_K = sel_shift(NCODE - 1);
   localparam int PRE_W = (MAX_K < 1) ? 1 : MAX_K;

   logic [PRE_W-1:0] pre_q;
   logic [NCODE-1:0] tick_vec;

   always_ff @(posedge clk) begin
      if (!rst_n)       pre_q <= '0;
      else if (!active) pre_q <= '0;
      else              pre_q <= pre_q + 1'b1;
   end

   generate
      for (genvar c = 0; c < NCODE; c++) begin : g_code
         localparam int K = sel_shift(c);
         if (K == 0) begin : g_direct
            assign tick_vec[c] = 1'b1;
         end else begin : g_div
            assign tick_vec[c] = &pre_q[K-1:0];
         end
      end
   endgenerate

   assign tick = active & tick_vec[sel];

   AST_PRE_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(active) |-> (pre_q == '0)); // R8

endmodule

// File: rtl/ivt_counter.sv
module ivt_counter #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             active,
   input  logic             tick,
   input  logic [CNT_W-1:0] cmp,
   output logic [CNT_W-1:0] cnt_q,
   output logic             irq_q
);

   logic hit;

   assign hit = (cnt_q == cmp);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
         irq_q <= 1'b0;
      end else begin
         irq_q <= active && tick && hit;
         if (!active)   cnt_q <= '0;
         else if (tick) cnt_q <= hit ? '0 : cnt_q + 1'b1;
      end
   end

   AST_CNT_LE_CMP: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= cmp); // R4

   AST_IRQ_AT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      irq_q |-> (cnt_q == '0)); // R5

   AST_STOP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      !active |=> (cnt_q == '0)); // R8

endmodule

// File: rtl/ivt_timer.sv
module ivt_timer
   import ivt_pkg::*;
#(
   parameter int CNT_W = 8,
   parameter int SEL_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [CNT_W-1:0]  wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [CNT_W-1:0]  rd_data,
   output logic              irq
);

   generate
      if (CNT_W < 4 || CNT_W > 32) begin : g_bad_cnt
         $error("ivt_timer: CNT_W must be 4..32");
      end
      if (SEL_W < 1 || SEL_W > 3) begin : g_bad_sel
         $error("ivt_timer: SEL_W must be 1..3");
      end
   endgenerate

   logic [CNT_W-1:0] cmp_q, cnt_q;
   logic [SEL_W-1:0] sel_q;
   logic             run_q, hold_q, active, tick;

   assign active = run_q & ~hold_q;

   ivt_regs #(.CNT_W(CNT_W), .SEL_W(SEL_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .rd_addr(rd_addr), .cnt(cnt_q), .rd_data(rd_data),
      .cmp_q(cmp_q), .sel_q(sel_q), .run_q(run_q), .hold_q(hold_q)
   );

   ivt_prescaler #(.SEL_W(SEL_W)) u_pre (
      .clk(clk), .rst_n(rst_n), .active(active), .sel(sel_q), .tick(tick)
   );

   ivt_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .active(active), .tick(tick),
      .cmp(cmp_q), .cnt_q(cnt_q), .irq_q(irq)
   );

   AST_HOLD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (run_q && hold_q && $past(run_q && hold_q)) |-> !irq); // R9

endmodule

// File: tb/tb_ivt_timer.sv
module tb_ivt_timer;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic [1:0] wr_addr = '0;
   logic [7:0] wr_data = '0;
   logic [1:0] rd_addr = '0;
   logic [7:0] rd_data;
   logic       irq;

   int  n_chk = 0;
   int  n_bad = 0;
   bit  done  = 0;

   always #4 clk = ~clk;

   ivt_timer dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq)
   );

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(posedge clk);
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output int v);
      rd_addr = a;
      #1;
      v = int'(rd_data);
   endtask

   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   function automatic int shift_of(input int code);
      int tbl[8] = '{0, 1, 2, 3, 4, 6, 8, 10};
      return tbl[code];
   endfunction

   // called right after the run=1 write returns (edge zero)
   task automatic wait_irqs(input int p, input string req);
      int first = -1, second = -1, after = 0;
      for (int j = 1; j <= 2 * p + 1; j++) begin
         step();
         if (first > 0 && j == first + 1) after = irq;
         if (irq) begin
            if (first < 0) first = j;
            else if (second < 0) second = j;
         end
      end
      chk({req, " first irq"}, first, p);
      chk({req, " second irq"}, second, 2 * p);
      if (p > 1) chk("R5 irq one cycle wide", after, 0);
   endtask

   task automatic measure(input int code, input int n, input string req);
      wr(2'd2, 8'h00);
      wr(2'd0, 8'(n));
      wr(2'd1, 8'(code));
      wr(2'd2, 8'h01);
      wait_irqs((n + 1) << shift_of(code), req);
   endtask

   task automatic t_reset();
      int v;
      rd(2'd0, v); chk("R1 compare", v, 0);
      rd(2'd1, v); chk("R1 select", v, 0);
      rd(2'd2, v); chk("R1 control", v, 0);
      rd(2'd3, v); chk("R1 counter", v, 0);
      chk("R1 irq", int'(irq), 0);
   endtask

   task automatic t_map();
      int v;
      wr(2'd0, 8'hA7); rd(2'd0, v); chk("R2 compare map", v, 8'hA7);
      wr(2'd1, 8'hFD); rd(2'd1, v); chk("R2 select bits", v, 5);
      wr(2'd2, 8'h02); rd(2'd2, v); chk("R2 control map", v, 2);
      rd(2'd3, v); chk("R2 counter idle", v, 0);
      wr(2'd2, 8'h00);
   endtask

   task automatic t_periods();
      measure(0, 5,   "R4 code0 N5");
      measure(0, 0,   "R4 code0 N0");
      measure(2, 3,   "R3 code2 N3");
      measure(4, 0,   "R3 code4 N0");
      measure(5, 1,   "R3 code5 N1");
      measure(3, 255, "R3 code3 N255");
      measure(7, 2,   "R3 code7 N2");
   endtask

   task automatic t_count();
      int v;
      wr(2'd2, 8'h00);
      wr(2'd0, 8'd200);
      wr(2'd1, 8'd0);
      wr(2'd2, 8'h01);
      rd(2'd3, v); chk("R6 counter at start", v, 0);
      for (int j = 0; j < 37; j++) step();
      rd(2'd3, v); chk("R6 counter after 37", v, 37);
   endtask

   task automatic t_lock();
      int v;
      wr(2'd0, 8'd9);
      rd(2'd0, v); chk("R7 compare locked", v, 200);
      wr(2'd2, 8'h00);
   endtask

   task automatic t_stop();
      int v, pulses = 0;
      wr(2'd0, 8'd3);
      wr(2'd1, 8'd2);
      wr(2'd2, 8'h01);
      for (int j = 0; j < 7; j++) step();
      wr(2'd2, 8'h00);
      step();
      rd(2'd3, v); chk("R8 counter cleared", v, 0);
      for (int j = 0; j < 40; j++) begin
         step();
         if (irq) pulses++;
      end
      chk("R8 no irq while stopped", pulses, 0);
      rd(2'd3, v); chk("R8 counter stays 0", v, 0);
      wr(2'd2, 8'h01);
      wait_irqs(16, "R8 restart full interval");
      wr(2'd2, 8'h00);
   endtask

   task automatic t_hold();
      int v, pulses = 0;
      wr(2'd0, 8'd2);
      wr(2'd1, 8'd0);
      wr(2'd2, 8'h03);
      for (int j = 0; j < 30; j++) begin
         step();
         if (irq) pulses++;
      end
      chk("R9 no irq in hold", pulses, 0);
      rd(2'd3, v); chk("R9 counter held", v, 0);
      wr(2'd2, 8'h01);
      wait_irqs(3, "R9 resume");
      wr(2'd2, 8'h00);
   endtask

   task automatic t_readonly();
      int v;
      wr(2'd0, 8'd17);
      wr(2'd3, 8'h55);
      rd(2'd3, v); chk("R10 counter unchanged", v, 0);
      rd(2'd0, v); chk("R10 compare unchanged", v, 17);
      rd(2'd2, v); chk("R10 control unchanged", v, 0);
   endtask

   initial begin
      repeat (4) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      step();
      t_reset();
      t_map();
      t_periods();
      t_count();
      t_lock();
      t_stop();
      t_hold();
      t_readonly();
      done = 1;
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

   initial begin
      #(200000 * 8);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog actual=timeout expected=finished");
         $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   end

endmodule